// File: doc/BRIEF.md
# Biphase Bit Synchroniser with Differential Decoder

This block takes the demodulated baseband of a biphase-coded data channel, one signed sample per strobe, and recovers the bit timing and the data. A local phase counter divides the stream into bit windows of nominally `SPB` samples, which is the 1187.5 Hz bit rate at the chosen sample rate. Two integrate-and-dump accumulators run over each window. The data wave weights the first half of the window positive and the second half negative, which extracts the biphase symbol. The quadrature wave, a quarter bit out of step, weights the middle half positive and the outer quarters negative. It sums to zero when the window sits on the symbol.

At every window end the signs of the two sums are compared. The result is a vote on whether the incoming symbols run late or early. Once enough votes agree, the next window is stretched or shrunk by one sample. The number of votes needed is the loop time constant. Software can fix it, or the block can pick it itself: fast while acquiring after reset, slow afterwards. The symbol is the sign of the data sum. The output bit is that symbol XOR the previous symbol. A weak flag marks bits whose data-sum magnitude falls under a threshold, so a later error corrector can use it.

Top module: `rdsbit_sync`

## Requirements
- R1: A bit window ends on its last accepted sample. `bit_stb` is high for exactly the one clock after the clock that accepted that sample. With no timing correction, strobe k follows the (k+1)*SPB-th accepted sample.
- R2: In the data sum, samples at window positions 0..SPB/2-1 count positive and later positions count negative. The symbol is 1 when the final sum is >= 0, so a zero sum gives 1, and 0 when the sum is negative.
- R3: `bit_data` is the window's symbol XOR the previous window's symbol. The previous symbol is 0 after reset. `bit_data` changes only in a cycle where `bit_stb` is high.
- R4: `bit_weak` is 1 when |data sum| < `weak_thr`, and 0 when it is equal to or above the threshold.
- R5: In the quadrature sum, samples at positions SPB/4..3*SPB/4-1 count positive and the others negative. At a window end, a non-zero quadrature sum votes +1 (late) when its sign matches the data sum's sign, and -1 (early) otherwise. When the vote total reaches +N, the next window is stretched to SPB+1 samples. When it reaches -N, the next window is shrunk to SPB-1 samples. The total then clears. A zero quadrature sum adds no vote.
- R6: A window that was itself stretched or shrunk casts no vote. A constant symbol stream delayed by 2 samples therefore settles with no further correction: from bit 4 onward in fast mode, and from bit 10 onward in slow mode.
- R7: `tc_mode` = 01 selects fast tracking (N = FAST_VOTES, default 1). `tc_mode` = 10 or 11 selects slow tracking (N = SLOW_VOTES, default 4).
- R8: `tc_mode` = 00 is automatic: fast for the first ACQ_BITS (default 8) windows after reset, slow after that.
- R9: During and right after reset, `bit_data`, `bit_stb` and `bit_weak` are 0.
- R10: `smp` is ignored in any cycle where `smp_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample strobe, one clock per baseband sample |
| smp | input | SMP_W | Signed baseband sample |
| tc_mode | input | 2 | Loop time constant: 00 auto, 01 fast, 1x slow |
| weak_thr | input | ACC_W | Unsigned threshold for the weak flag |
| bit_data | output | 1 | Differentially decoded bit |
| bit_stb | output | 1 | One-clock pulse per recovered bit |
| bit_weak | output | 1 | Weak-decision flag for the bit |

## Verification
All three outputs are registered on the clock that accepts a window's final sample. The bench feeds one sample every other clock and reads the outputs on the falling edge that follows. There, the strobe, bit and flag of that window are all visible, and the running sample count must equal (k+1)*SPB while the timing is untouched. Loop behaviour is due a whole window late, because a correction changes the length of the next window. The bench therefore judges tracking by which bit indices carry the weak flag: bits before the promised settling index must still be weak, and bits after it must be strong.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_e;

  // Data wave: first half of the bit window counts positive.
  function automatic logic data_pos(input int ph, input int spb);
    return ph < spb / 2;
  endfunction

  // Quadrature wave: middle half of the window counts positive.
  function automatic logic quad_pos(input int ph, input int spb);
    return (ph >= spb / 4) && (ph < (3 * spb) / 4);
  endfunction

endpackage

// File: rtl/bsync_phase.sv
module bsync_phase
  import bsync_pkg::*;
#(
  parameter int SPB  = 16,
  parameter int PH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  input  adj_e            adj_req,
  output logic [PH_W-1:0] ph,
  output adj_e            cur_adj,
  output logic            bnd
);

  localparam logic [PH_W-1:0] PH_NOM   = PH_W'(SPB - 1);
  localparam logic [PH_W-1:0] PH_LONG  = PH_W'(SPB);
  localparam logic [PH_W-1:0] PH_SHORT = PH_W'(SPB - 2);

  logic [PH_W-1:0] end_ph;

  always_comb begin
    case (cur_adj)
      ADJ_LONG:  end_ph = PH_LONG;
      ADJ_SHORT: end_ph = PH_SHORT;
      default:   end_ph = PH_NOM;
    endcase
  end

  assign bnd = smp_en && (ph == end_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      cur_adj <= ADJ_NONE;
    end else if (smp_en) begin
      if (bnd) begin
        ph      <= '0;
        cur_adj <= adj_req;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  // R5
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_LONG);

  // R6
  no_back_to_back_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && cur_adj != ADJ_NONE) |=> (cur_adj == ADJ_NONE));

endmodule

// File: rtl/bsync_integ.sv
module bsync_integ
  import bsync_pkg::*;
#(
  parameter int SPB   = 16,
  parameter int PH_W  = 5,
  parameter int SMP_W = 12,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    bnd,
  input  logic [PH_W-1:0]         ph,
  input  logic signed [SMP_W-1:0] smp,
  output logic signed [ACC_W-1:0] data_sum,
  output logic signed [ACC_W-1:0] quad_sum
);

  localparam int NWAVE = 2;

  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] fin [NWAVE];

  assign ext = {{(ACC_W - SMP_W){smp[SMP_W-1]}}, smp};

  for (genvar g = 0; g < NWAVE; g++) begin : g_wave
    logic signed [ACC_W-1:0] acc;
    logic                    pos;

    assign pos    = (g == 0) ? data_pos(int'(ph), SPB) : quad_pos(int'(ph), SPB);
    assign fin[g] = pos ? (acc + ext) : (acc - ext);

    always_ff @(posedge clk) begin
      if (!rst_n)      acc <= '0;
      else if (bnd)    acc <= '0;
      else if (smp_en) acc <= fin[g];
    end
  end

  assign data_sum = fin[0];
  assign quad_sum = fin[1];

endmodule

// File: rtl/bsync_loop.sv
module bsync_loop
  import bsync_pkg::*;
#(
  parameter int FAST_VOTES = 1,
  parameter int SLOW_VOTES = 4,
  parameter int ACQ_BITS   = 8,
  parameter int ACC_W      = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bnd,
  input  adj_e                    cur_adj,
  input  logic                    data_neg,
  input  logic signed [ACC_W-1:0] quad_sum,
  input  logic [1:0]              tc_mode,
  output adj_e                    adj_req
);

  localparam int VW = $clog2(SLOW_VOTES + 1) + 1;
  localparam int AW = $clog2(ACQ_BITS + 1);
  localparam logic [AW-1:0] ACQ_MAX = AW'(ACQ_BITS);

  logic signed [VW-1:0] vote, vote_nx;
  logic [AW-1:0]        acq;
  logic                 late, early, fast;
  int                   vn, need;

  assign late  = (quad_sum != '0) && (quad_sum[ACC_W-1] == data_neg);
  assign early = (quad_sum != '0) && (quad_sum[ACC_W-1] != data_neg);
  assign fast  = (tc_mode == 2'b01) || ((tc_mode == 2'b00) && (acq < ACQ_MAX));

  always_comb begin
    vn      = int'(vote) + (late ? 1 : 0) - (early ? 1 : 0);
    need    = fast ? FAST_VOTES : SLOW_VOTES;
    adj_req = ADJ_NONE;
    vote_nx = vote;
    if (bnd && cur_adj == ADJ_NONE) begin
      if (vn >= need) begin
        adj_req = ADJ_LONG;
        vote_nx = '0;
      end else if (vn <= -need) begin
        adj_req = ADJ_SHORT;
        vote_nx = '0;
      end else begin
        vote_nx = VW'(vn);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote <= '0;
      acq  <= '0;
    end else begin
      vote <= vote_nx;
      if (bnd && acq != ACQ_MAX) acq <= acq + AW'(1);
    end
  end

  // R7
  vote_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vote) < SLOW_VOTES) && (int'(vote) > -SLOW_VOTES));

  // R5
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && quad_sum == '0) |-> (adj_req == ADJ_NONE));

endmodule

// File: rtl/bsync_decide.sv
module bsync_decide #(
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bnd,
  input  logic signed [ACC_W-1:0] data_sum,
  input  logic [ACC_W-1:0]        weak_thr,
  output logic                    bit_data,
  output logic                    bit_stb,
  output logic                    bit_weak
);

  function automatic logic [ACC_W-1:0] mag(input logic signed [ACC_W-1:0] x);
    return x[ACC_W-1] ? ACC_W'(-x) : ACC_W'(x);
  endfunction

  logic cur_sym, prev_sym, is_weak;

  assign cur_sym = ~data_sum[ACC_W-1];
  assign is_weak = mag(data_sum) < weak_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_data <= 1'b0;
      bit_stb  <= 1'b0;
      bit_weak <= 1'b0;
      prev_sym <= 1'b0;
    end else if (bnd) begin
      bit_data <= cur_sym ^ prev_sym;
      bit_weak <= is_weak;
      prev_sym <= cur_sym;
      bit_stb  <= 1'b1;
    end else begin
      bit_stb <= 1'b0;
    end
  end

  // R1
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> ($stable(bit_data) && $stable(bit_weak)));

endmodule

// File: rtl/rdsbit_sync.sv
module rdsbit_sync
  import bsync_pkg::*;
#(
  parameter int SMP_W      = 12,
  parameter int SPB        = 16,
  parameter int FAST_VOTES = 1,
  parameter int SLOW_VOTES = 4,
  parameter int ACQ_BITS   = 8,
  parameter int ACC_W      = SMP_W + $clog2(SPB + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [SMP_W-1:0] smp,
  input  logic [1:0]              tc_mode,
  input  logic [ACC_W-1:0]        weak_thr,
  output logic                    bit_data,
  output logic                    bit_stb,
  output logic                    bit_weak
);

  localparam int PH_W = $clog2(SPB + 1);

  logic [PH_W-1:0]         ph;
  logic                    bnd;
  adj_e                    cur_adj, adj_req;
  logic signed [ACC_W-1:0] data_sum, quad_sum;

  bsync_phase #(.SPB(SPB), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .adj_req(adj_req),
    .ph(ph), .cur_adj(cur_adj), .bnd(bnd)
  );

  bsync_integ #(.SPB(SPB), .PH_W(PH_W), .SMP_W(SMP_W), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .bnd(bnd), .ph(ph), .smp(smp),
    .data_sum(data_sum), .quad_sum(quad_sum)
  );

  bsync_loop #(.FAST_VOTES(FAST_VOTES), .SLOW_VOTES(SLOW_VOTES),
               .ACQ_BITS(ACQ_BITS), .ACC_W(ACC_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .cur_adj(cur_adj),
    .data_neg(data_sum[ACC_W-1]), .quad_sum(quad_sum), .tc_mode(tc_mode),
    .adj_req(adj_req)
  );

  bsync_decide #(.ACC_W(ACC_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .data_sum(data_sum),
    .weak_thr(weak_thr), .bit_data(bit_data), .bit_stb(bit_stb),
    .bit_weak(bit_weak)
  );

  // R10
  bnd_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> $past(smp_en));

endmodule

// File: tb/sim_rdsbit_sync.sv
module sim_rdsbit_sync;

  localparam int CLK_P = 10;
  localparam int SPB   = 16;
  localparam int SMP_W = 12;
  localparam int ACC_W = 18;
  localparam int NV    = 12;

  typedef struct packed {
    logic        sym;
    logic [11:0] amp;
    logic        ebit;
    logic        eweak;
  } vec_t;

  // Threshold 640 = 16*40 during the table walk.
  localparam vec_t TV [NV] = '{
    '{1'b1, 12'd100, 1'b1, 1'b0},
    '{1'b1, 12'd40,  1'b0, 1'b0},
    '{1'b0, 12'd39,  1'b1, 1'b1},
    '{1'b0, 12'd100, 1'b0, 1'b0},
    '{1'b1, 12'd20,  1'b1, 1'b1},
    '{1'b0, 12'd100, 1'b1, 1'b0},
    '{1'b1, 12'd40,  1'b1, 1'b0},
    '{1'b1, 12'd100, 1'b0, 1'b0},
    '{1'b0, 12'd39,  1'b1, 1'b1},
    '{1'b1, 12'd100, 1'b1, 1'b0},
    '{1'b0, 12'd0,   1'b0, 1'b1},
    '{1'b0, 12'd100, 1'b1, 1'b0}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    smp_en = 1'b0;
  logic signed [SMP_W-1:0] smp = '0;
  logic [1:0]              tc_mode = 2'b01;
  logic [ACC_W-1:0]        weak_thr = '0;
  logic                    bit_data, bit_stb, bit_weak;

  int  n_chk = 0, n_fail = 0;
  int  nsent = 0, nstb = 0, long_stb = 0;
  bit  prev_stb = 1'b0;
  bit  got_bit  [256];
  bit  got_weak [256];
  int  got_cnt  [256];

  always #(CLK_P / 2) clk = ~clk;

  rdsbit_sync u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp(smp), .tc_mode(tc_mode),
    .weak_thr(weak_thr), .bit_data(bit_data), .bit_stb(bit_stb), .bit_weak(bit_weak)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_stb) begin
        if (nstb < 256) begin
          got_bit[nstb]  = bit_data;
          got_weak[nstb] = bit_weak;
          got_cnt[nstb]  = nsent;
        end
        nstb++;
        if (prev_stb) long_stb++;
      end
      prev_stb = bit_stb;
    end else begin
      prev_stb = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_en = 1'b0;
    repeat (3) @(negedge clk);
    nsent = 0; nstb = 0; long_stb = 0;
    rst_n = 1'b1;
  endtask

  // One accepted sample followed by an idle cycle carrying junk (R10).
  task automatic send(input int v);
    @(negedge clk);
    smp = SMP_W'(v); smp_en = 1'b1; nsent++;
    @(negedge clk);
    smp_en = 1'b0; smp = -12'sd2000;
  endtask

  task automatic send_sym(input bit sym, input int amp);
    for (int i = 0; i < SPB; i++)
      send(((i < SPB / 2) == sym) ? amp : -amp);
  endtask

  task automatic delayed_run(input int nsym);
    send(-100); send(-100);
    for (int i = 0; i < nsym; i++) send_sym(1'b1, 100);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    // R9 reset state
    do_reset();
    @(negedge clk);
    chk(bit_stb == 1'b0,  "R9 bit_stb after reset", int'(bit_stb), 0);
    chk(bit_data == 1'b0, "R9 bit_data after reset", int'(bit_data), 0);
    chk(bit_weak == 1'b0, "R9 bit_weak after reset", int'(bit_weak), 0);

    // Table walk: aligned stream, fast mode, threshold 640
    tc_mode = 2'b01; weak_thr = ACC_W'(640);
    for (int k = 0; k < NV; k++) send_sym(TV[k].sym, int'(TV[k].amp));
    repeat (4) @(negedge clk);
    chk(nstb == NV, "R1 strobe count", nstb, NV);
    chk(long_stb == 0, "R1 strobe longer than one cycle", long_stb, 0);
    for (int k = 0; k < NV; k++) begin
      chk(got_bit[k] == TV[k].ebit, "R2/R3/R10 decoded bit", int'(got_bit[k]), int'(TV[k].ebit));
      chk(got_weak[k] == TV[k].eweak, "R4 weak flag", int'(got_weak[k]), int'(TV[k].eweak));
      chk(got_cnt[k] == (k + 1) * SPB, "R1 strobe sample position", got_cnt[k], (k + 1) * SPB);
    end

    // Fast tracking of a 2-sample delay, threshold 1600 = 16*100
    do_reset();
    tc_mode = 2'b01; weak_thr = ACC_W'(1600);
    delayed_run(16);
    chk(got_weak[0] == 1'b1, "R5 offset shows as weak bit0", int'(got_weak[0]), 1);
    chk(got_weak[1] == 1'b1, "R5 offset shows as weak bit1", int'(got_weak[1]), 1);
    for (int k = 4; k < 15; k++)
      chk(got_weak[k] == 1'b0, "R6 fast settled", int'(got_weak[k]), 0);
    chk(got_bit[0] == 1'b1, "R3 first decoded bit", int'(got_bit[0]), 1);
    chk(got_bit[8] == 1'b0, "R3 constant symbols decode 0", int'(got_bit[8]), 0);

    // Slow tracking from reset
    do_reset();
    tc_mode = 2'b10; weak_thr = ACC_W'(1600);
    delayed_run(20);
    for (int k = 0; k < 5; k++)
      chk(got_weak[k] == 1'b1, "R7 slow still offset", int'(got_weak[k]), 1);
    for (int k = 10; k < 19; k++)
      chk(got_weak[k] == 1'b0, "R6/R7 slow settled", int'(got_weak[k]), 0);

    // Automatic: fast acquisition, then slow after ACQ_BITS windows
    do_reset();
    tc_mode = 2'b00; weak_thr = ACC_W'(1600);
    send(-100); send(-100);
    for (int i = 0; i < 40; i++) send_sym(1'b1, 100);
    send(-100); send(-100);
    for (int i = 0; i < 12; i++) send_sym(1'b1, 100);
    repeat (4) @(negedge clk);
    for (int k = 4; k < 40; k++)
      chk(got_weak[k] == 1'b0, "R8 auto acquires fast", int'(got_weak[k]), 0);
    chk(got_weak[44] == 1'b1, "R8 auto slow after acquisition", int'(got_weak[44]), 1);
    chk(got_weak[50] == 1'b0, "R8 auto slow re-settles", int'(got_weak[50]), 0);

    // R4 boundary: threshold one above the exact sum
    do_reset();
    tc_mode = 2'b01; weak_thr = ACC_W'(1601);
    send_sym(1'b0, 100);
    repeat (2) @(negedge clk);
    chk(got_weak[0] == 1'b1, "R4 sum just under threshold", int'(got_weak[0]), 1);
    chk(got_bit[0] == 1'b0, "R2/R3 negative symbol after reset", int'(got_bit[0]), 0);

    summary();
  end

endmodule